// File: doc/BRIEF.md
# Cycle-Stealing DMA Channel Engine

This block is one DMA channel that copies data from a source address to a destination address over a simple master bus. Software sets it up through a small register port. There are two address registers, a 24-bit count of units, a channel control word and a global operation word. Each unit is moved as a read from the source followed by a write to the destination. In cycle-steal mode the channel gives the bus back after every unit and asks for it again before the next one. In burst mode it keeps the bus from the grant until the count is used up. Units are started either by an internal auto-request or by an external request pin, whose sense the control word selects.

The sequencer has five states:

- `ST_IDLE`: waits for the enables and a request. It checks alignment and then either raises the address error or moves to `ST_ARB`.
- `ST_ARB`: holds `bus_req` until `bus_gnt` arrives, then moves to `ST_RD`.
- `ST_RD`: a source read. It moves to `ST_WR` when `mem_ready` is high.
- `ST_WR`: a destination write. It moves to `ST_RD` for the next longword of a 16-byte unit, and otherwise to `ST_STEP`.
- `ST_STEP`: updates the count. It goes back to `ST_IDLE` (releasing the bus) when the count ends, in cycle-steal mode, or when a burst can no longer continue. It goes straight to `ST_RD` when a burst continues.

Register map by `reg_addr`: 0 is the source address, 1 the destination address, 2 the count (low 24 bits) and 3 the control word. Address 4 is the operation word: bit 0 is the global enable and bit 1 is the address-error flag. The control word bits are:

| Bits | Field |
|------|-------|
| 0 | channel enable |
| 1 | end interrupt enable |
| 2 | done flag |
| 3 | burst |
| 5:4 | size |
| 7:6 | source mode |
| 9:8 | destination mode |
| 13:10 | request select |
| 15:14 | request sense |
| 16 | acknowledge polarity |
| 17 | end-strobe polarity |
| 18 | half interrupt enable |
| 19 | half flag |

Both flags (done and half) are clear-only: writing 0 to the bit clears it, and writing 1 leaves it unchanged.

Top module: `dma_steal_chan`

## Requirements
- R1: After reset every register reads 0, `bus_req`, `mem_valid`, `irq_half` and `irq_end` are 0, and `dack` and `tend` sit at their inactive level 1 (polarity bits 0 mean active-low).
- R2: Each unit reads from the source address and writes the read data to the destination address. Size 00/01/10/11 moves 1/2/4/16 bytes, and a 16-byte unit is four longword read/write pairs. Data is right-justified on the bus.
- R3: Address mode 00 keeps the address fixed, 01 adds and 10 subtracts the beat size (1, 2 or 4 bytes) after each write beat.
- R4: In cycle-steal mode (burst bit 0) `bus_req` drops after every unit, so a transfer of N units shows N rising edges of `bus_req`.
- R5: In burst mode with auto-request the bus is requested once and held until the count is exhausted.
- R6: In burst mode with a level-sensed request, a request that goes inactive lets the current unit finish and then releases the bus, with the count left above 0.
- R7: Request select 0100 is auto-request; any other value uses the `dreq` pin with sense 00 low level, 01 high level, 10 rising edge or 11 falling edge. Each edge starts exactly one unit.
- R8: Units start only when the channel enable bit and the global enable bit are both 1. Clearing the channel enable stops further units.
- R9: The count drops by one per unit. When it reaches 0 the done flag (bit 2) sets and no further units start until it is cleared. A programmed count of 0 means 16,777,216 units.
- R10: The half flag (bit 19) sets when the remaining count equals floor(N/2). `irq_half` is the half flag ANDed with bit 18, and `irq_end` is the done flag ANDed with bit 1.
- R11: A source or destination address not aligned to the unit size sets the address error (operation bit 1) with no bus activity. Transfers stay halted until the flag is cleared.
- R12: `dack` is at its active level (bit 16) during every read and write cycle. `tend` is at its active level (bit 17) only during the last write cycle of the final unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | External transfer request |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Bus cycle active |
| mem_write | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | 32 | Bus address |
| mem_size | output | 2 | Beat size: 00 byte, 01 word, 10 longword |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Bus cycle completes |
| dack | output | 1 | Transfer acknowledge, programmable polarity |
| tend | output | 1 | Final-write strobe, programmable polarity |
| irq_half | output | 1 | Half-way interrupt |
| irq_end | output | 1 | Completion interrupt |

## Verification
The hardest case to reach from the ports is a burst that ends early. A level-sensed request has to fall while the channel holds the bus between units. The bench raises `dreq` in high-level mode, waits a few cycles so that several units have gone by, and then drops it. It then checks that the bus request rose only once, that the count stopped strictly between its start value and 0, and that the count stays frozen afterwards. The 2^24 count cannot be run to the end, so the bench starts it, stops it with the channel enable, and checks that the count has wrapped just below 2^24 and that the done flag is still clear.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_RD,
        ST_WR,
        ST_STEP
    } seq_state_t;

    // register selects
    localparam logic [2:0] RA_SRC = 3'd0;
    localparam logic [2:0] RA_DST = 3'd1;
    localparam logic [2:0] RA_CNT = 3'd2;
    localparam logic [2:0] RA_CTL = 3'd3;
    localparam logic [2:0] RA_OP  = 3'd4;

    // control word fields
    localparam int CF_EN      = 0;
    localparam int CF_END_IE  = 1;
    localparam int CF_TE      = 2;
    localparam int CF_BURST   = 3;
    localparam int CF_SIZE    = 4;
    localparam int CF_SMODE   = 6;
    localparam int CF_DMODE   = 8;
    localparam int CF_RSEL    = 10;
    localparam int CF_SENSE   = 14;
    localparam int CF_ACK_POL = 16;
    localparam int CF_END_POL = 17;
    localparam int CF_HALF_IE = 18;
    localparam int CF_HE      = 19;

    // operation word fields
    localparam int OF_GEN = 0;
    localparam int OF_AE  = 1;

    localparam logic [3:0] RSEL_AUTO = 4'b0100;
    localparam logic [1:0] SZ_16     = 2'b11;

    function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   beat_bytes = 3'd1;
            2'b01:   beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [3:0] unit_mask(input logic [1:0] sz);
        case (sz)
            2'b00:   unit_mask = 4'h0;
            2'b01:   unit_mask = 4'h1;
            2'b10:   unit_mask = 4'h3;
            default: unit_mask = 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/dma_req_sense.sv
module dma_req_sense (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dreq,
    input  logic [1:0] sense,
    input  logic       accept,
    output logic       ext_req
);
    logic dreq_q;
    logic pend;
    logic edge_mode;
    logic hit;

    assign edge_mode = sense[1];
    assign hit       = sense[0] ? (dreq_q & ~dreq) : (~dreq_q & dreq);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreq_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            dreq_q <= dreq;
            if (!edge_mode)
                pend <= 1'b0;
            else if (hit)
                pend <= 1'b1;
            else if (accept)
                pend <= 1'b0;
        end
    end

    assign ext_req = edge_mode ? pend : (sense[0] ? dreq : ~dreq);
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              beat_adv,
    input  logic              unit_done,
    input  logic              ae_set,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [31:0]       ctl_q,
    output logic              gen_en,
    output logic              ae_flag
);
    localparam logic [CNT_W-1:0] HALF_FULL = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0]  half_mark;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  cnt_wval;
    logic [ADDR_W-1:0] src_step;
    logic [ADDR_W-1:0] dst_step;
    logic wr_src, wr_dst, wr_cnt, wr_ctl, wr_op;

    function automatic logic [ADDR_W-1:0] delta(input logic [1:0] mode, input logic [1:0] sz);
        logic [ADDR_W-1:0] st;
        st = ADDR_W'(beat_bytes(sz));
        case (mode)
            2'b01:   delta = st;
            2'b10:   delta = -st;
            default: delta = '0;
        endcase
    endfunction

    assign src_step = delta(ctl_q[CF_SMODE+:2], ctl_q[CF_SIZE+:2]);
    assign dst_step = delta(ctl_q[CF_DMODE+:2], ctl_q[CF_SIZE+:2]);
    assign cnt_next = cnt_q - CNT_W'(1);
    assign cnt_wval = CNT_W'(reg_wdata);
    assign wr_src   = reg_we && (reg_addr == RA_SRC);
    assign wr_dst   = reg_we && (reg_addr == RA_DST);
    assign wr_cnt   = reg_we && (reg_addr == RA_CNT);
    assign wr_ctl   = reg_we && (reg_addr == RA_CTL);
    assign wr_op    = reg_we && (reg_addr == RA_OP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
            half_mark <= '0;
            ctl_q     <= '0;
            gen_en    <= 1'b0;
            ae_flag   <= 1'b0;
        end else begin
            if (beat_adv) begin
                src_q <= src_q + src_step;
                dst_q <= dst_q + dst_step;
            end
            if (wr_src) src_q <= ADDR_W'(reg_wdata);
            if (wr_dst) dst_q <= ADDR_W'(reg_wdata);
            if (unit_done) cnt_q <= cnt_next;
            if (wr_cnt) begin
                cnt_q     <= cnt_wval;
                half_mark <= (cnt_wval == '0) ? HALF_FULL : (cnt_wval >> 1);
            end
            if (wr_ctl) begin
                ctl_q        <= reg_wdata;
                ctl_q[CF_TE] <= ctl_q[CF_TE] & reg_wdata[CF_TE];
                ctl_q[CF_HE] <= ctl_q[CF_HE] & reg_wdata[CF_HE];
            end
            if (unit_done && (cnt_q == CNT_W'(1))) ctl_q[CF_TE] <= 1'b1;
            if (unit_done && (cnt_next == half_mark)) ctl_q[CF_HE] <= 1'b1;
            if (wr_op) begin
                gen_en  <= reg_wdata[OF_GEN];
                ae_flag <= ae_flag & reg_wdata[OF_AE];
            end
            if (ae_set) ae_flag <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_SRC:  reg_rdata = 32'(src_q);
            RA_DST:  reg_rdata = 32'(dst_q);
            RA_CNT:  reg_rdata = 32'(cnt_q);
            RA_CTL:  reg_rdata = ctl_q;
            RA_OP:   reg_rdata = {30'd0, ae_flag, gen_en};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_steal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_ok,
    input  logic        req_ok,
    input  logic        cont_ok,
    input  logic        burst,
    input  logic [1:0]  size,
    input  logic        misaligned,
    input  logic        cnt_last,
    input  logic        bus_gnt,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output seq_state_t  state,
    output logic        accept,
    output logic        ae_set,
    output logic        beat_adv,
    output logic        unit_done,
    output logic        bus_req,
    output logic        mem_valid,
    output logic        mem_write,
    output logic        last_wr,
    output logic [31:0] data_q
);
    seq_state_t nxt;
    logic [1:0] beat_q;
    logic       more_beats;

    assign more_beats = (size == SZ_16) && (beat_q != 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            beat_q <= '0;
            data_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_RD && mem_ready) data_q <= mem_rdata;
            if (state == ST_WR && mem_ready) beat_q <= more_beats ? beat_q + 2'd1 : 2'd0;
        end
    end

    always_comb begin
        nxt       = state;
        accept    = 1'b0;
        ae_set    = 1'b0;
        beat_adv  = 1'b0;
        unit_done = 1'b0;
        unique case (state)
            ST_IDLE: if (run_ok && req_ok) begin
                if (misaligned) ae_set = 1'b1;
                else begin
                    accept = 1'b1;
                    nxt    = ST_ARB;
                end
            end
            ST_ARB: if (bus_gnt) nxt = ST_RD;
            ST_RD:  if (mem_ready) nxt = ST_WR;
            ST_WR: if (mem_ready) begin
                beat_adv = 1'b1;
                nxt      = more_beats ? ST_RD : ST_STEP;
            end
            ST_STEP: begin
                unit_done = 1'b1;
                if (cnt_last) nxt = ST_IDLE;
                else if (burst && run_ok && cont_ok) nxt = ST_RD;
                else nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req   = (state != ST_IDLE);
        mem_valid = (state == ST_RD) || (state == ST_WR);
        mem_write = (state == ST_WR);
        last_wr   = (state == ST_WR) && cnt_last && !more_beats;
    end
endmodule

// File: rtl/dma_steal_chan.sv
module dma_steal_chan
    import dma_steal_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dreq,
    output logic        bus_req,
    input  logic        bus_gnt,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [1:0]  mem_size,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        dack,
    output logic        tend,
    output logic        irq_half,
    output logic        irq_end
);
    logic [31:0]      src_q, dst_q, ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             gen_en, ae_flag, te_flag, burst_md;
    logic             beat_adv, unit_done, ae_set, accept, last_wr;
    logic             ext_req, auto_sel, run_ok, req_ok, cont_ok;
    logic             misaligned, cnt_last, cnt_sw_wr;
    logic [1:0]       size;
    seq_state_t       seq_st;

    dma_regfile #(.ADDR_W(32), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_adv(beat_adv),
        .unit_done(unit_done), .ae_set(ae_set), .src_q(src_q), .dst_q(dst_q),
        .cnt_q(cnt_q), .ctl_q(ctl_q), .gen_en(gen_en), .ae_flag(ae_flag)
    );

    dma_req_sense u_sense (
        .clk(clk), .rst_n(rst_n), .dreq(dreq), .sense(ctl_q[CF_SENSE+:2]),
        .accept(accept), .ext_req(ext_req)
    );

    assign size       = ctl_q[CF_SIZE+:2];
    assign te_flag    = ctl_q[CF_TE];
    assign burst_md   = ctl_q[CF_BURST];
    assign auto_sel   = (ctl_q[CF_RSEL+:4] == RSEL_AUTO);
    assign run_ok     = ctl_q[CF_EN] && gen_en && !te_flag && !ae_flag;
    assign req_ok     = auto_sel || ext_req;
    assign cont_ok    = auto_sel || ctl_q[CF_SENSE+1] || ext_req;
    assign misaligned = |((src_q[3:0] | dst_q[3:0]) & unit_mask(size));
    assign cnt_last   = (cnt_q == CNT_W'(1));
    assign cnt_sw_wr  = reg_we && (reg_addr == RA_CNT);

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .req_ok(req_ok),
        .cont_ok(cont_ok), .burst(burst_md), .size(size),
        .misaligned(misaligned), .cnt_last(cnt_last), .bus_gnt(bus_gnt),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .state(seq_st),
        .accept(accept), .ae_set(ae_set), .beat_adv(beat_adv),
        .unit_done(unit_done), .bus_req(bus_req), .mem_valid(mem_valid),
        .mem_write(mem_write), .last_wr(last_wr), .data_q(mem_wdata)
    );

    assign mem_addr = mem_write ? dst_q : src_q;
    assign mem_size = (size == SZ_16) ? 2'b10 : size;
    assign dack     = mem_valid ? ctl_q[CF_ACK_POL] : ~ctl_q[CF_ACK_POL];
    assign tend     = last_wr ? ctl_q[CF_END_POL] : ~ctl_q[CF_END_POL];
    assign irq_half = ctl_q[CF_HE] && ctl_q[CF_HALF_IE];
    assign irq_end  = te_flag && ctl_q[CF_END_IE];
endmodule

// File: rtl/dma_steal_chan_chk.sv
module dma_steal_chan_chk
    import dma_steal_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             mem_valid,
    input logic             burst_md,
    input seq_state_t       seq_st,
    input logic             te_flag,
    input logic             ae_flag,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cnt_sw_wr
);
    p_cycle_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_req && bus_gnt));

    p_steal_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_STEP && !burst_md) |=> !bus_req);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        te_flag |-> !mem_valid);

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_sw_wr |=> ($stable(cnt_q) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

    p_error_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ae_flag |-> !mem_valid);
endmodule

bind dma_steal_chan dma_steal_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .burst_md(burst_md), .seq_st(seq_st),
    .te_flag(te_flag), .ae_flag(ae_flag), .cnt_q(cnt_q), .cnt_sw_wr(cnt_sw_wr)
);

// File: tb/sim_dma_steal_chan.sv
`timescale 1ns/1ps
module sim_dma_steal_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dreq = 1'b0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready;
    logic        dack, tend, irq_half, irq_end;

    int total = 0;
    int bad = 0;
    logic [7:0] mem [256];
    logic [7:0] expm [256];
    int rises = 0, vcyc = 0, dcyc = 0, tcyc = 0;
    logic req_prev = 1'b0;
    logic pol_a = 1'b0, pol_t = 1'b0;

    always #2.5 clk = ~clk;

    dma_steal_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dack(dack), .tend(tend), .irq_half(irq_half), .irq_end(irq_end)
    );

    // bus slave: grant one cycle after request, zero-wait memory
    assign mem_ready = mem_valid;
    always @(posedge clk) bus_gnt <= rst_n ? bus_req : 1'b0;
    always_comb begin
        mem_rdata = {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                     mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
    end
    always @(posedge clk) begin
        if (mem_valid && mem_write) begin
            for (int b = 0; b < ((mem_size == 2'b00) ? 1 : (mem_size == 2'b01) ? 2 : 4); b++)
                mem[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
        end
    end

    always @(negedge clk) begin
        if (bus_req && !req_prev) rises++;
        req_prev = bus_req;
        if (mem_valid) vcyc++;
        if (dack == pol_a) dcyc++;
        if (tend == pol_t) tcyc++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_te(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            rd(3'd3, v);
            if (v[2]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i * 37 + 11);
            expm[i] = 8'(i * 37 + 11);
        end
    endtask

    function automatic logic [31:0] ctlw(input int sz, input int sm, input int dm,
                                         input int bm, input int rsel, input int sense);
        return 32'(1 | (bm << 3) | (sz << 4) | (sm << 6) | (dm << 8) | (rsel << 10) | (sense << 14));
    endfunction

    // sweep one configuration with auto-request, 3 units
    task automatic run_cfg(input int sz, input int sm, input int dm, input int bm);
        int s0, d0, sdir, ddir, step, beats, r0;
        bit ok, same;
        logic [31:0] v;
        s0 = (sm == 1) ? 'h10 : (sm == 2) ? 'h40 : 'h20;
        d0 = (dm == 1) ? 'h80 : (dm == 2) ? 'hF0 : 'h90;
        sdir = (sm == 1) ? 1 : (sm == 2) ? -1 : 0;
        ddir = (dm == 1) ? 1 : (dm == 2) ? -1 : 0;
        step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        beats = 3 * ((sz == 3) ? 4 : 1);
        init_mem();
        wr(3'd0, 32'(s0));
        wr(3'd1, 32'(d0));
        wr(3'd2, 32'd3);
        r0 = rises;
        wr(3'd3, ctlw(sz, sm, dm, bm, 4, 0));
        wait_te(ok);
        idle(3);
        for (int j = 0; j < beats; j++)
            for (int b = 0; b < step; b++)
                expm[8'(d0 + ddir * j * step + b)] = expm[8'(s0 + sdir * j * step + b)];
        same = 1'b1;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) same = 1'b0;
        chk(same, $sformatf("R2 data sz=%0d sm=%0d dm=%0d", sz, sm, dm), same, 1);
        rd(3'd2, v);
        chk(ok && v == 0, "R9 count done", v, 0);
        rd(3'd0, v);
        chk(v == 32'(s0 + sdir * beats * step), "R3 src final", v, 32'(s0 + sdir * beats * step));
        rd(3'd1, v);
        chk(v == 32'(d0 + ddir * beats * step), "R3 dst final", v, 32'(d0 + ddir * beats * step));
        chk((rises - r0) == (bm ? 1 : 3), bm ? "R5 one tenure" : "R4 tenure per unit",
            rises - r0, bm ? 1 : 3);
        wr(3'd3, 32'd0);
    endtask

    task automatic pulse(input logic lvl);
        dreq = lvl; idle(2);
        dreq = ~lvl; idle(20);
    endtask

    initial begin
        logic [31:0] v, c1, c2;
        int v0, d0c, t0c, r0;
        bit ok;
        init_mem();
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(!bus_req && !mem_valid && !irq_half && !irq_end, "R1 outputs idle",
            {bus_req, mem_valid, irq_half, irq_end}, 0);
        chk(dack && tend, "R1 strobes inactive", {dack, tend}, 2'b11);

        // R8 global enable gating
        wr(3'd0, 32'h20); wr(3'd1, 32'h90); wr(3'd2, 32'd5);
        v0 = vcyc;
        wr(3'd3, ctlw(2, 0, 0, 0, 4, 0));
        idle(30);
        rd(3'd2, v);
        chk(v == 5 && vcyc == v0, "R8 no run without global enable", v, 5);
        wr(3'd4, 32'd1);
        wait_te(ok);
        chk(ok, "R8 runs with both enables", ok, 1);
        wr(3'd3, 32'd0);

        // sweep: size x source mode x destination mode x bus mode
        for (int sz = 0; sz < 4; sz++)
            for (int sm = 0; sm < 3; sm++)
                for (int dm = 0; dm < 3; dm++)
                    for (int bm = 0; bm < 2; bm++)
                        run_cfg(sz, sm, dm, bm);

        // R8 clearing channel enable stops further units
        wr(3'd0, 32'h20); wr(3'd1, 32'h90); wr(3'd2, 32'd200);
        wr(3'd3, ctlw(2, 0, 0, 0, 4, 0));
        idle(40);
        wr(3'd3, 32'd0);
        idle(20);
        rd(3'd2, c1);
        idle(30);
        rd(3'd2, c2);
        chk(c1 == c2 && c1 < 200 && c1 > 0, "R8 stop on enable clear", c2, c1);

        // R7 level-low external request
        wr(3'd2, 32'd4);
        dreq = 1'b1;
        v0 = vcyc;
        wr(3'd3, ctlw(2, 0, 0, 0, 0, 0));
        idle(30);
        chk(vcyc == v0, "R7 inactive low-level request idle", vcyc - v0, 0);
        dreq = 1'b0;
        wait_te(ok);
        rd(3'd2, v);
        chk(ok && v == 0, "R7 low-level request completes", v, 0);
        wr(3'd3, 32'd0);

        // R6 level-high burst ended early
        wr(3'd2, 32'd20);
        r0 = rises;
        wr(3'd3, ctlw(2, 0, 0, 1, 0, 1));
        dreq = 1'b1;
        idle(10);
        dreq = 1'b0;
        idle(30);
        rd(3'd2, c1);
        chk(!bus_req && c1 > 0 && c1 < 20, "R6 burst released early", c1, 10);
        chk(rises - r0 == 1, "R6 single tenure", rises - r0, 1);
        idle(30);
        rd(3'd2, c2);
        chk(c2 == c1, "R6 count frozen", c2, c1);
        wr(3'd3, 32'd0);

        // R7 and R10 rising edges, half flag and end interrupt
        wr(3'd2, 32'd4);
        wr(3'd3, ctlw(2, 0, 0, 0, 0, 2) | 32'h40002);
        idle(5);
        pulse(1'b1);
        rd(3'd3, v);
        rd(3'd2, c1);
        chk(c1 == 3 && !v[19] && !irq_half, "R7 one unit per rising edge", c1, 3);
        pulse(1'b1);
        rd(3'd3, v);
        chk(v[19] && irq_half, "R10 half flag at floor(N/2)", {v[19], irq_half}, 2'b11);
        pulse(1'b1);
        chk(!irq_end, "R10 no end interrupt early", irq_end, 0);
        pulse(1'b1);
        rd(3'd3, v);
        chk(v[2] && irq_end, "R10 end interrupt", {v[2], irq_end}, 2'b11);
        pulse(1'b1);
        rd(3'd2, c1);
        chk(c1 == 0, "R9 request ignored after done", c1, 0);
        wr(3'd3, 32'd0);
        chk(!irq_end && !irq_half, "R10 flags cleared", {irq_end, irq_half}, 0);

        // R7 falling edges
        dreq = 1'b1;
        idle(3);
        wr(3'd2, 32'd3);
        wr(3'd3, ctlw(2, 0, 0, 0, 0, 3));
        idle(5);
        pulse(1'b0);
        pulse(1'b0);
        rd(3'd2, c1);
        chk(c1 == 1, "R7 one unit per falling edge", c1, 1);
        wr(3'd3, 32'd0);
        dreq = 1'b0;
        idle(3);

        // R11 misaligned address
        wr(3'd0, 32'h12); wr(3'd1, 32'h90); wr(3'd2, 32'd2);
        v0 = vcyc;
        wr(3'd3, ctlw(2, 0, 0, 0, 4, 0));
        idle(20);
        rd(3'd4, v);
        rd(3'd2, c1);
        chk(v == 3 && c1 == 2 && vcyc == v0, "R11 address error halts", v, 3);
        wr(3'd0, 32'h10);
        wr(3'd4, 32'd1);
        wait_te(ok);
        chk(ok, "R11 resumes after clear", ok, 1);
        wr(3'd3, 32'd0);

        // R12 polarity and strobe timing, longword
        wr(3'd0, 32'h20); wr(3'd1, 32'h90); wr(3'd2, 32'd3);
        wr(3'd3, 32'h30000);
        pol_a = 1'b1; pol_t = 1'b1;
        idle(2);
        d0c = dcyc; t0c = tcyc;
        wr(3'd3, ctlw(2, 0, 0, 0, 4, 0) | 32'h30000);
        wait_te(ok);
        chk(dcyc - d0c == 6, "R12 dack active cycles", dcyc - d0c, 6);
        chk(tcyc - t0c == 1, "R12 tend single cycle", tcyc - t0c, 1);
        wr(3'd3, 32'h30000);

        // R12 active-low, 16-byte units
        wr(3'd2, 32'd2);
        wr(3'd3, 32'd0);
        pol_a = 1'b0; pol_t = 1'b0;
        idle(2);
        d0c = dcyc; t0c = tcyc;
        wr(3'd3, ctlw(3, 0, 0, 0, 4, 0));
        wait_te(ok);
        chk(dcyc - d0c == 16, "R12 dack active-low cycles", dcyc - d0c, 16);
        chk(tcyc - t0c == 1, "R12 tend on last beat only", tcyc - t0c, 1);
        wr(3'd3, 32'd0);

        // R9 programmed count of zero means 2^24 units
        wr(3'd2, 32'd0);
        wr(3'd3, ctlw(2, 0, 0, 0, 4, 0));
        idle(60);
        rd(3'd3, v);
        wr(3'd3, 32'd0);
        idle(20);
        rd(3'd2, c1);
        chk(!v[2] && c1 > 32'hFFFF00 && c1 <= 32'hFFFFFF, "R9 zero count is 2^24", c1, 32'hFFFFF0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog R1-timeout actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule